// File: doc/BRIEF.md
# PHY power and disable controller

This block is the power-management control inside a gigabit Ethernet PHY. It watches an active-low disable pin and steps through a small sequence. While the pin is asserted, the PHY is quiet: the MAC-side serial link sits in electrical idle, the link clock towards the MAC is gated off, every output buffer is tri-stated and wake-on-LAN is forced off. The block itself runs on the reference clock, which it never gates, so the only thing the PHY can still do is come back up.

When the pin is released, the block brings the PHY back in a fixed order. First it re-enables the link clock to the MAC. Then it waits for the MAC's reset-sync handshake, with a timeout that raises a sticky error flag and continues anyway. Then it runs the normal initialization sequencer and finally enters the running state. Power-up after reset follows the same path. The synchronized pin is adopted only after two agreeing samples, so a one-cycle glitch is filtered out.

The block also selects the speed policy for auto-negotiation: full speed, low-power link-up, or battery saver. The policy is evaluated and latched only when the negotiation engine signals the start of an attempt. A change of the MAC's low-power bit therefore affects only the next attempt, and the block has no way to start a negotiation itself. The policy does not depend on whether the system runs from mains or battery.

Top module: `phy_pwr_ctrl`

## Requirements
- R1: While reset is held, and after it is released with the disable pin low, `out_tristate_o`=1, `link_idle_o`=1, `link_clk_en_o`=0, `wol_en_o`=0, `init_run_o`=0, `sync_err_o`=0 and `policy_o`=0 (full speed). Internal reset release takes two clock edges after `rst_n` rises.
- R2: While disabled, `out_tristate_o`=1, `link_idle_o`=1 and `link_clk_en_o`=0. A pin level seen on two consecutive clock edges is adopted, and the outputs reflect it after the fourth edge that follows the first of those samples.
- R3: `wol_en_o` equals `wol_cfg_i` only in the running state. It is 0 while the PHY is disabled or coming back up.
- R4: After release, the block leaves the tri-state and raises `link_clk_en_o` while `link_idle_o` stays 1. On a cycle with `mac_rst_sync_i`=1 it moves to initialization (`init_run_o`=1). On `init_done_i`=1 it runs, with `link_idle_o`=0 and `init_run_o`=0.
- R5: If no reset-sync arrives within `SYNC_TIMEOUT` cycles of waiting, the block enters initialization with `sync_err_o`=1. The flag stays set until the next time the block leaves the disabled state.
- R6: Asserting the disable pin during the wait, initialization or running state returns the block to the disabled state.
- R7: `policy_o` (0 full speed, 1 low-power link-up, 2 battery saver) is updated only on a cycle with `neg_start_i`=1, one edge later. At all other times it holds, whatever the policy inputs do.
- R8: When no battery-saver override applies, the latched policy is 1 if `dev_state_i`=0 (fully active) and `lplu_bit_i`=1, or if `dev_state_i`≠0 and `nvm_lplu_en_i`=1. Otherwise it is 0. `lplu_eff_o` is 1 exactly when `policy_o`=1.
- R9: With `sys_s0_i`=1 and `batt_saver_req_i`=1 at the start, the latched policy is 2 regardless of the other policy inputs. With `sys_s0_i`=0 the saver request has no effect.
- R10: A disable pulse that is low on a single sampling edge leaves the running state untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, never gated by the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| disable_n_i | input | 1 | Asynchronous active-low PHY disable pin |
| mac_rst_sync_i | input | 1 | Reset-sync handshake from the MAC |
| init_done_i | input | 1 | Initialization sequencer finished |
| wol_cfg_i | input | 1 | Wake-on-LAN requested by configuration |
| lplu_bit_i | input | 1 | Low-power link-up bit written by the MAC |
| nvm_lplu_en_i | input | 1 | Non-volatile enable of low-power link-up outside the active state |
| dev_state_i | input | DEV_STATE_W | Device power state, 0 = fully active |
| sys_s0_i | input | 1 | System is in its fully-on state |
| batt_saver_req_i | input | 1 | Battery-saver speed request |
| neg_start_i | input | 1 | Negotiation attempt begins this cycle |
| link_idle_o | output | 1 | Hold MAC-side serial link in electrical idle |
| link_clk_en_o | output | 1 | Enable of the link clock to the MAC |
| out_tristate_o | output | 1 | Tri-state all PHY output buffers |
| wol_en_o | output | 1 | Wake-on-LAN enabled |
| init_run_o | output | 1 | Run the initialization sequencer |
| sync_err_o | output | 1 | Reset-sync wait timed out |
| policy_o | output | 2 | Latched negotiation speed policy |
| lplu_eff_o | output | 1 | Latched low-power link-up in effect |

## Verification
The release sequence is driven three ways: with a prompt reset-sync, with no reset-sync at all so that the timeout path runs, and with the disable pin reasserted in each intermediate state. Together these separate the handshake order from the timeout and abort paths. A single-cycle low glitch, set against a sustained low level, tells the two-sample filter apart from a plain synchronizer. The policy latch is tried with every combination of device state, MAC bit, non-volatile enable and saver request. The policy inputs are also changed between start pulses, which shows whether a value is latched or passed straight through.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;

  typedef enum logic [1:0] {
    PS_OFF       = 2'd0,
    PS_WAIT_SYNC = 2'd1,
    PS_INIT      = 2'd2,
    PS_RUN       = 2'd3
  } pwr_state_t;

  typedef enum logic [1:0] {
    POL_FULL  = 2'd0,
    POL_LOW   = 2'd1,
    POL_SAVER = 2'd2
  } neg_policy_t;

endpackage

// File: rtl/pwr_dis_filter.sv
module pwr_dis_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  output logic dis_o
);
  logic meta_q, sync_q, sync_d_q, dis_q;
  logic dis_d;

  always_comb begin
    dis_d = dis_q;
    if (sync_q == sync_d_q) dis_d = ~sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= 1'b0;
      sync_q   <= 1'b0;
      sync_d_q <= 1'b0;
      dis_q    <= 1'b1;
    end else begin
      meta_q   <= pin_n_i;
      sync_q   <= meta_q;
      sync_d_q <= sync_q;
      dis_q    <= dis_d;
    end
  end

  assign dis_o = dis_q;
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import phy_pwr_pkg::*;
#(
  parameter int SYNC_TIMEOUT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dis_i,
  input  logic       mac_rst_sync_i,
  input  logic       init_done_i,
  output pwr_state_t state_o,
  output logic       err_o
);
  localparam int TW = $clog2(SYNC_TIMEOUT + 1);
  localparam logic [TW-1:0] TMR_LAST = TW'(SYNC_TIMEOUT - 1);

  pwr_state_t st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic tmr_en;
  logic err_q, err_d;

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    tmr_en = 1'b0;
    err_d  = err_q;
    unique case (st_q)
      PS_OFF: begin
        if (!dis_i) begin
          st_d   = PS_WAIT_SYNC;
          tmr_d  = '0;
          tmr_en = 1'b1;
          err_d  = 1'b0;
        end
      end
      PS_WAIT_SYNC: begin
        if (dis_i) begin
          st_d = PS_OFF;
        end else if (mac_rst_sync_i) begin
          st_d = PS_INIT;
        end else if (tmr_q == TMR_LAST) begin
          st_d  = PS_INIT;
          err_d = 1'b1;
        end else begin
          tmr_d  = tmr_q + 1'b1;
          tmr_en = 1'b1;
        end
      end
      PS_INIT: begin
        if (dis_i)            st_d = PS_OFF;
        else if (init_done_i) st_d = PS_RUN;
      end
      PS_RUN: begin
        if (dis_i) st_d = PS_OFF;
      end
      default: st_d = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_OFF;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  assign state_o = st_q;
  assign err_o   = err_q;
endmodule

// File: rtl/neg_policy_latch.sv
module neg_policy_latch
  import phy_pwr_pkg::*;
#(
  parameter int DEV_STATE_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   lplu_bit_i,
  input  logic                   nvm_en_i,
  input  logic [DEV_STATE_W-1:0] dev_state_i,
  input  logic                   sys_s0_i,
  input  logic                   saver_req_i,
  output neg_policy_t            policy_o
);
  localparam logic [DEV_STATE_W-1:0] DEV_ACTIVE = '0;

  neg_policy_t pol_q, pol_d, pol_eval;
  logic low_ok;

  always_comb begin
    low_ok = (dev_state_i == DEV_ACTIVE) ? lplu_bit_i : nvm_en_i;
    if (sys_s0_i && saver_req_i) pol_eval = POL_SAVER;
    else if (low_ok)             pol_eval = POL_LOW;
    else                         pol_eval = POL_FULL;
    pol_d = start_i ? pol_eval : pol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pol_q <= POL_FULL;
    else        pol_q <= pol_d;
  end

  assign policy_o = pol_q;
endmodule

// File: rtl/phy_pwr_ctrl.sv
module phy_pwr_ctrl
  import phy_pwr_pkg::*;
#(
  parameter int SYNC_TIMEOUT = 16,
  parameter int DEV_STATE_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disable_n_i,
  input  logic                   mac_rst_sync_i,
  input  logic                   init_done_i,
  input  logic                   wol_cfg_i,
  input  logic                   lplu_bit_i,
  input  logic                   nvm_lplu_en_i,
  input  logic [DEV_STATE_W-1:0] dev_state_i,
  input  logic                   sys_s0_i,
  input  logic                   batt_saver_req_i,
  input  logic                   neg_start_i,
  output logic                   link_idle_o,
  output logic                   link_clk_en_o,
  output logic                   out_tristate_o,
  output logic                   wol_en_o,
  output logic                   init_run_o,
  output logic                   sync_err_o,
  output logic [1:0]             policy_o,
  output logic                   lplu_eff_o
);
  logic rst_meta_q, rst_int_n;
  logic dis_flt;
  pwr_state_t st;
  logic seq_err;
  neg_policy_t pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  pwr_dis_filter u_filt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .pin_n_i (disable_n_i),
    .dis_o   (dis_flt)
  );

  pwr_seq_fsm #(.SYNC_TIMEOUT(SYNC_TIMEOUT)) u_seq (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .dis_i          (dis_flt),
    .mac_rst_sync_i (mac_rst_sync_i),
    .init_done_i    (init_done_i),
    .state_o        (st),
    .err_o          (seq_err)
  );

  neg_policy_latch #(.DEV_STATE_W(DEV_STATE_W)) u_pol (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (neg_start_i),
    .lplu_bit_i  (lplu_bit_i),
    .nvm_en_i    (nvm_lplu_en_i),
    .dev_state_i (dev_state_i),
    .sys_s0_i    (sys_s0_i),
    .saver_req_i (batt_saver_req_i),
    .policy_o    (pol)
  );

  always_comb begin
    out_tristate_o = (st == PS_OFF);
    link_clk_en_o  = (st != PS_OFF);
    link_idle_o    = (st != PS_RUN);
    init_run_o     = (st == PS_INIT);
    wol_en_o       = wol_cfg_i && (st == PS_RUN);
    sync_err_o     = seq_err;
    policy_o       = pol;
    lplu_eff_o     = (pol == POL_LOW);
  end
endmodule

// File: rtl/phy_pwr_ctrl_chk.sv
module phy_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       neg_start_i,
  input logic       sys_s0_i,
  input logic       batt_saver_req_i,
  input logic       link_idle_o,
  input logic       link_clk_en_o,
  input logic       out_tristate_o,
  input logic       wol_en_o,
  input logic       init_run_o,
  input logic       sync_err_o,
  input logic [1:0] policy_o
);
  // R2: disabled outputs travel together
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_tristate_o |-> (link_idle_o && !link_clk_en_o));

  // R3: no wake-on-LAN without the link clock running
  a_r3_wol_off: assert property (@(posedge clk) disable iff (!rst_n)
    !link_clk_en_o |-> !wol_en_o);

  // R4: initialization starts only after the link clock was already on
  a_r4_clk_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_run_o) |-> $past(link_clk_en_o));

  // R5: a timeout flag appears together with initialization
  a_r5_err_init: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_err_o) |-> init_run_o);

  // R7: policy holds without a start pulse
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !neg_start_i |=> $stable(policy_o));

  // R9: saver override
  a_r9_saver: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_start_i && sys_s0_i && batt_saver_req_i) |=> (policy_o == 2'd2));
endmodule

bind phy_pwr_ctrl phy_pwr_ctrl_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_int_n),
  .neg_start_i      (neg_start_i),
  .sys_s0_i         (sys_s0_i),
  .batt_saver_req_i (batt_saver_req_i),
  .link_idle_o      (link_idle_o),
  .link_clk_en_o    (link_clk_en_o),
  .out_tristate_o   (out_tristate_o),
  .wol_en_o         (wol_en_o),
  .init_run_o       (init_run_o),
  .sync_err_o       (sync_err_o),
  .policy_o         (policy_o)
);

// File: tb/phy_pwr_ctrl_tb_top.sv
module phy_pwr_ctrl_tb_top;
  localparam int TO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disable_n_i = 1'b0, mac_rst_sync_i = 1'b0, init_done_i = 1'b0;
  logic wol_cfg_i = 1'b0, lplu_bit_i = 1'b0, nvm_lplu_en_i = 1'b0;
  logic [1:0] dev_state_i = 2'd0;
  logic sys_s0_i = 1'b0, batt_saver_req_i = 1'b0, neg_start_i = 1'b0;
  logic link_idle_o, link_clk_en_o, out_tristate_o, wol_en_o;
  logic init_run_o, sync_err_o, lplu_eff_o;
  logic [1:0] policy_o;

  int checks = 0, failures = 0, cyc = 0;
  bit cmp_en = 0, done = 0;

  always #4 clk = ~clk;

  phy_pwr_ctrl #(.SYNC_TIMEOUT(TO), .DEV_STATE_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .disable_n_i(disable_n_i),
    .mac_rst_sync_i(mac_rst_sync_i), .init_done_i(init_done_i),
    .wol_cfg_i(wol_cfg_i), .lplu_bit_i(lplu_bit_i),
    .nvm_lplu_en_i(nvm_lplu_en_i), .dev_state_i(dev_state_i),
    .sys_s0_i(sys_s0_i), .batt_saver_req_i(batt_saver_req_i),
    .neg_start_i(neg_start_i), .link_idle_o(link_idle_o),
    .link_clk_en_o(link_clk_en_o), .out_tristate_o(out_tristate_o),
    .wol_en_o(wol_en_o), .init_run_o(init_run_o), .sync_err_o(sync_err_o),
    .policy_o(policy_o), .lplu_eff_o(lplu_eff_o)
  );

  // Reference model: mode 0 off, 1 waiting for sync, 2 init, 3 running
  int m_mode, m_wait, m_rcnt, m_pol;
  bit m_dis, m_err;
  bit pin_hist[$];

  task automatic model_reset();
    m_mode = 0; m_wait = 0; m_pol = 0; m_dis = 1; m_err = 0;
    pin_hist = '{0, 0, 0, 0};
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rcnt = 0; model_reset();
    end else if (m_rcnt < 2) begin
      m_rcnt++; model_reset();
    end else begin
      case (m_mode)
        0: if (!m_dis) begin m_mode = 1; m_wait = 0; m_err = 0; end
        1: if (m_dis) m_mode = 0;
           else if (mac_rst_sync_i) m_mode = 2;
           else if (m_wait == TO - 1) begin m_mode = 2; m_err = 1; end
           else m_wait++;
        2: if (m_dis) m_mode = 0; else if (init_done_i) m_mode = 3;
        default: if (m_dis) m_mode = 0;
      endcase
      pin_hist.push_front(disable_n_i);
      void'(pin_hist.pop_back());
      if (pin_hist[2] == pin_hist[3]) m_dis = !pin_hist[2];
      if (neg_start_i) begin
        if (sys_s0_i && batt_saver_req_i) m_pol = 2;
        else if (dev_state_i == 2'd0) m_pol = lplu_bit_i ? 1 : 0;
        else m_pol = nvm_lplu_en_i ? 1 : 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always begin
    @(posedge clk); #2;
    if (cmp_en) begin
      chk(out_tristate_o == (m_mode == 0), "R2 tristate", out_tristate_o, m_mode == 0);
      chk(link_clk_en_o == (m_mode != 0), "R2 link clock", link_clk_en_o, m_mode != 0);
      chk(link_idle_o == (m_mode != 3), "R4 idle", link_idle_o, m_mode != 3);
      chk(init_run_o == (m_mode == 2), "R4 init", init_run_o, m_mode == 2);
      chk(wol_en_o == (wol_cfg_i && m_mode == 3), "R3 wol", wol_en_o, wol_cfg_i && m_mode == 3);
      chk(sync_err_o == m_err, "R5 err", sync_err_o, m_err);
      chk(int'(policy_o) == m_pol, "R7 policy", policy_o, m_pol);
      chk(lplu_eff_o == (m_pol == 1), "R8 lplu_eff", lplu_eff_o, m_pol == 1);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1; failures++; checks++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    neg_start_i = 1; tick(1); neg_start_i = 0; tick(2);
  endtask

  initial begin
    tick(1); cmp_en = 1;
    tick(3); rst_n = 1; tick(6);
    // R1 reset state
    chk(out_tristate_o && link_idle_o && !link_clk_en_o && !wol_en_o && !init_run_o
        && !sync_err_o && policy_o == 0, "R1 reset state", out_tristate_o, 1);

    // R4 normal release
    disable_n_i = 1; tick(8);
    chk(link_clk_en_o && !out_tristate_o && link_idle_o, "R4 clock restarted", link_clk_en_o, 1);
    mac_rst_sync_i = 1; tick(1); mac_rst_sync_i = 0; tick(2);
    chk(init_run_o == 1, "R4 init after sync", init_run_o, 1);
    init_done_i = 1; tick(1); init_done_i = 0; tick(2);
    chk(link_idle_o == 0, "R4 running", link_idle_o, 0);

    // R3 wake-on-LAN follows config in running state
    wol_cfg_i = 1; tick(2);
    chk(wol_en_o == 1, "R3 wol in run", wol_en_o, 1);

    // R10 one-cycle glitch ignored
    disable_n_i = 0; tick(1); disable_n_i = 1; tick(8);
    chk(link_idle_o == 0 && !out_tristate_o, "R10 glitch ignored", link_idle_o, 0);

    // R2 sustained disable
    disable_n_i = 0; tick(8);
    chk(out_tristate_o && !link_clk_en_o, "R2 disabled", out_tristate_o, 1);
    chk(wol_en_o == 0, "R3 wol forced off", wol_en_o, 0);

    // R5 timeout path
    disable_n_i = 1; tick(TO + 12);
    chk(sync_err_o && init_run_o, "R5 timeout", sync_err_o, 1);
    init_done_i = 1; tick(1); init_done_i = 0; tick(2);
    chk(sync_err_o == 1, "R5 sticky", sync_err_o, 1);

    // R6 abort from running, then from wait (flag cleared on leaving off)
    disable_n_i = 0; tick(8); disable_n_i = 1; tick(7);
    chk(sync_err_o == 0, "R5 cleared", sync_err_o, 0);
    disable_n_i = 0; tick(8);
    chk(out_tristate_o == 1, "R6 abort wait", out_tristate_o, 1);
    disable_n_i = 1; tick(8);
    mac_rst_sync_i = 1; tick(1); mac_rst_sync_i = 0; tick(1);
    disable_n_i = 0; tick(8);
    chk(out_tristate_o == 1 && !init_run_o, "R6 abort init", out_tristate_o, 1);

    // R8 / R7 / R9 policy selection
    dev_state_i = 0; lplu_bit_i = 1; pulse_start();
    chk(policy_o == 1 && lplu_eff_o, "R8 active lplu", policy_o, 1);
    lplu_bit_i = 0; nvm_lplu_en_i = 1; sys_s0_i = 1; batt_saver_req_i = 1; tick(5);
    chk(policy_o == 1, "R7 hold without start", policy_o, 1);
    batt_saver_req_i = 0; sys_s0_i = 0; pulse_start();
    chk(policy_o == 0, "R8 active no lplu", policy_o, 0);
    dev_state_i = 2; nvm_lplu_en_i = 0; lplu_bit_i = 1; pulse_start();
    chk(policy_o == 0, "R8 nonactive nvm off", policy_o, 0);
    nvm_lplu_en_i = 1; lplu_bit_i = 0; pulse_start();
    chk(policy_o == 1, "R8 nonactive nvm on", policy_o, 1);
    sys_s0_i = 1; batt_saver_req_i = 1; dev_state_i = 0; lplu_bit_i = 1; pulse_start();
    chk(policy_o == 2 && !lplu_eff_o, "R9 saver override", policy_o, 2);
    sys_s0_i = 0; pulse_start();
    chk(policy_o == 1, "R9 no override outside S0", policy_o, 1);
    tick(4);

    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule